// File: doc/BRIEF.md
# Opcode-Fetch Bus Cycle Sequencer

This block drives the memory-control strobes of a classic 8-bit processor bus from the CPU clock and a per-clock cycle request. It is a cycle-accurate bus master. A memory or DRAM controller under test sees the same strobe shapes and edge placement that a real processor would produce. Instruction decode, wait states, interrupts and bus arbitration are not part of it.

Two kinds of bus cycle are produced:

- **Opcode fetch.** It runs four clocks (T1..T4). The read strobes are low for one and a half clocks. The last two clocks are then used for a refresh phase, which carries a 7-bit refresh address.
- **Data read or data write.** It runs three clocks. The memory strobe stays low for two and a half clocks, and there is no refresh.

The requester presents a cycle kind, an address and write data every clock. The sequencer samples them on a rising edge when it is idle or in the final T-state of the current cycle. Back-to-back cycles therefore need no gap.

The strobes change on both clock edges. Each strobe is decoded from the rising-edge T-state register and its falling-edge copy.

Top module: `bus_cycle_seq`

## Requirements
- R1: A request kind is encoded 2'b00 none, 2'b01 opcode fetch, 2'b10 data read, 2'b11 data write. It is sampled on a rising edge when the sequencer is idle or in the last T-state. An opcode fetch then runs exactly four clocks, and a data read or write runs exactly three. Cycles may follow each other with no idle clock.
- R2: In an opcode fetch, mem_req_n and rd_n go low on the falling edge inside T1. They return high on the rising edge that begins T3.
- R3: fetch_n is low from the start of T1 to the rising edge that begins T3 of an opcode fetch, and it is high in every other clock.
- R4: During T3 and T4 of an opcode fetch, refresh_n is low and rd_n stays high. In the same fetch, mem_req_n is low again from the falling edge in T3 to the falling edge in T4.
- R5: rfsh_addr is 7 bits wide and is 0 after reset. It increments by one on the rising edge that ends each refresh phase, and wraps from 127 to 0.
- R6: In a data cycle, mem_req_n and the read or write strobe go low on the falling edge inside T1. They return high on the rising edge that ends T3, which is two and a half clocks. fetch_n and refresh_n stay high.
- R7: wr_n goes low only in data write cycles. wr_data_oe is high for the whole write cycle, and wr_data carries the write data sampled with the request.
- R8: sample_stb is high for the clock that ends in the rising edge at which read data is taken. That clock is T2 of an opcode fetch and T3 of a data read.
- R9: With no cycle running, every strobe is high, and sample_stb and wr_data_oe are low. A synchronous reset returns the block to this state and clears rfsh_addr.
- R10: bus_addr holds the address sampled with the request for the whole cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous reset, active high |
| req_kind | input | 2 | Requested cycle kind |
| req_addr | input | 16 | Address for the requested cycle |
| req_wdata | input | 8 | Write data for the requested cycle |
| mem_req_n | output | 1 | Memory request strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| fetch_n | output | 1 | Opcode-fetch marker, active low |
| refresh_n | output | 1 | Refresh phase marker, active low |
| rfsh_addr | output | 7 | Refresh row address |
| bus_addr | output | 16 | Bus address of the current cycle |
| wr_data | output | 8 | Write data of the current cycle |
| wr_data_oe | output | 1 | Write data drive enable |
| sample_stb | output | 1 | High in the clock whose ending edge samples read data |

## Verification
The assertions watch the following on every rising edge:
- the exclusions between strobes, so that refresh never overlaps a read or fetch marker and a write never overlaps a read;
- that wr_n low implies wr_data_oe high;
- the one-step increment of the refresh address after each refresh phase, and that it holds still otherwise;
- that sample_stb only appears while a read strobe is low;
- the all-idle state after reset.

Other behaviour depends on where edges fall inside a clock: the half-clock placement of each falling and rising strobe edge, the cycle lengths, back-to-back acceptance and the 127-to-0 wrap. The bench shows these by comparing both halves of every clock against its behavioural model.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    typedef enum logic [1:0] {
        CYC_NONE  = 2'b00,
        CYC_FETCH = 2'b01,
        CYC_READ  = 2'b10,
        CYC_WRITE = 2'b11
    } cyc_kind_e;

    typedef enum logic [2:0] {
        TS_IDLE = 3'd0,
        TS_1    = 3'd1,
        TS_2    = 3'd2,
        TS_3    = 3'd3,
        TS_4    = 3'd4
    } tstate_e;

    typedef struct packed {
        cyc_kind_e kind;
        tstate_e   ts;
    } phase_t;

    localparam phase_t PHASE_IDLE = '{kind: CYC_NONE, ts: TS_IDLE};

    function automatic tstate_e final_ts(cyc_kind_e k);
        return (k == CYC_FETCH) ? TS_4 : TS_3;
    endfunction

    function automatic logic can_accept(phase_t p);
        return (p.ts == TS_IDLE) || (p.ts == final_ts(p.kind));
    endfunction

    function automatic tstate_e step_ts(tstate_e t);
        case (t)
            TS_1:    return TS_2;
            TS_2:    return TS_3;
            TS_3:    return TS_4;
            default: return TS_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/bseq_tstate.sv
module bseq_tstate
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output phase_t            ph,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q
);

    cyc_kind_e req_k;
    assign req_k = cyc_kind_e'(req_kind);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PHASE_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (can_accept(ph)) begin
            if (req_k != CYC_NONE) begin
                ph      <= '{kind: req_k, ts: TS_1};
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end else begin
                ph <= PHASE_IDLE;
            end
        end else begin
            ph.ts <= step_ts(ph.ts);
        end
    end

endmodule

// File: rtl/bseq_halfphase.sv
module bseq_halfphase
    import bseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_t ph,
    output phase_t ph_fall
);

    always_ff @(negedge clk) begin
        if (rst) ph_fall <= PHASE_IDLE;
        else     ph_fall <= ph;
    end

endmodule

// File: rtl/bseq_refresh.sv
module bseq_refresh
    import bseq_pkg::*;
#(
    parameter int RFSH_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_t            ph,
    output logic [RFSH_W-1:0] row
);

    logic refresh_done;
    assign refresh_done = (ph.kind == CYC_FETCH) && (ph.ts == TS_4);

    always_ff @(posedge clk) begin
        if (rst)               row <= '0;
        else if (refresh_done) row <= row + RFSH_W'(1);
    end

endmodule

// File: rtl/bseq_strobes.sv
module bseq_strobes
    import bseq_pkg::*;
(
    input  phase_t ph,
    input  phase_t ph_fall,
    output logic   mem_req_n,
    output logic   rd_n,
    output logic   wr_n,
    output logic   fetch_n,
    output logic   refresh_n,
    output logic   sample_stb,
    output logic   wr_data_oe
);

    logic is_fetch, is_read, is_write, early_t1;
    logic fetch_access, data_window, refresh_req;

    always_comb begin
        is_fetch = (ph.kind == CYC_FETCH);
        is_read  = (ph.kind == CYC_READ);
        is_write = (ph.kind == CYC_WRITE);
        // T1 before its falling edge: the falling-edge copy still holds the previous phase
        early_t1 = (ph.ts == TS_1) && (ph_fall.ts != TS_1);

        fetch_access = is_fetch &&
                       (((ph.ts == TS_1) && !early_t1) || (ph.ts == TS_2));
        data_window  = (is_read || is_write) &&
                       (((ph.ts == TS_1) && !early_t1) ||
                        (ph.ts == TS_2) || (ph.ts == TS_3));
        refresh_req  = is_fetch && (ph_fall.kind == CYC_FETCH) &&
                       (ph_fall.ts == TS_3) &&
                       ((ph.ts == TS_3) || (ph.ts == TS_4));

        mem_req_n  = !(fetch_access || data_window || refresh_req);
        rd_n       = !(fetch_access || (data_window && is_read));
        wr_n       = !(data_window && is_write);
        fetch_n    = !(is_fetch && ((ph.ts == TS_1) || (ph.ts == TS_2)));
        refresh_n  = !(is_fetch && ((ph.ts == TS_3) || (ph.ts == TS_4)));
        sample_stb = (is_fetch && (ph.ts == TS_2)) || (is_read && (ph.ts == TS_3));
        wr_data_oe = is_write && (ph.ts != TS_IDLE);
    end

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int RFSH_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              mem_req_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              fetch_n,
    output logic              refresh_n,
    output logic [RFSH_W-1:0] rfsh_addr,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_data_oe,
    output logic              sample_stb
);

    phase_t ph, ph_fall;

    bseq_tstate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tstate (
        .clk       (clk),
        .rst       (rst),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ph        (ph),
        .addr_q    (bus_addr),
        .wdata_q   (wr_data)
    );

    bseq_halfphase u_half (
        .clk     (clk),
        .rst     (rst),
        .ph      (ph),
        .ph_fall (ph_fall)
    );

    bseq_refresh #(.RFSH_W(RFSH_W)) u_rfsh (
        .clk (clk),
        .rst (rst),
        .ph  (ph),
        .row (rfsh_addr)
    );

    bseq_strobes u_strb (
        .ph         (ph),
        .ph_fall    (ph_fall),
        .mem_req_n  (mem_req_n),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .fetch_n    (fetch_n),
        .refresh_n  (refresh_n),
        .sample_stb (sample_stb),
        .wr_data_oe (wr_data_oe)
    );

endmodule

// File: rtl/bus_cycle_seq_chk.sv
module bus_cycle_seq_chk #(
    parameter int RFSH_W = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_req_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic              fetch_n,
    input logic              refresh_n,
    input logic [RFSH_W-1:0] rfsh_addr,
    input logic              wr_data_oe,
    input logic              sample_stb
);

    p_write_drives_data_r7: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> (wr_data_oe && rd_n));

    p_fetch_not_refresh_r3: assert property (@(posedge clk) disable iff (rst)
        !fetch_n |-> refresh_n);

    p_refresh_no_read_r4: assert property (@(posedge clk) disable iff (rst)
        !refresh_n |-> (rd_n && wr_n && fetch_n));

    p_refresh_row_step_r5: assert property (@(posedge clk) disable iff (rst)
        (!refresh_n && $past(!refresh_n)) |=>
            (rfsh_addr == RFSH_W'($past(rfsh_addr) + 1'b1)));

    p_refresh_row_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (refresh_n && $past(refresh_n)) |=> $stable(rfsh_addr));

    p_sample_while_read_r8: assert property (@(posedge clk) disable iff (rst)
        sample_stb |-> (!rd_n && !mem_req_n));

    p_idle_after_reset_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mem_req_n && rd_n && wr_n && fetch_n && refresh_n &&
                        !wr_data_oe && !sample_stb));

endmodule

bind bus_cycle_seq bus_cycle_seq_chk #(.RFSH_W(RFSH_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mem_req_n  (mem_req_n),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .fetch_n    (fetch_n),
    .refresh_n  (refresh_n),
    .rfsh_addr  (rfsh_addr),
    .wr_data_oe (wr_data_oe),
    .sample_stb (sample_stb)
);

// File: tb/sim_bus_cycle_seq.sv
`timescale 1ns/1ps
module sim_bus_cycle_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  req_kind = 2'b00;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        mem_req_n, rd_n, wr_n, fetch_n, refresh_n, wr_data_oe, sample_stb;
    logic [6:0]  rfsh_addr;
    logic [15:0] bus_addr;
    logic [7:0]  wr_data;

    int n_checks = 0;
    int n_errors = 0;

    // reference model state
    int          m_kind = 0;
    int          m_t = 0;
    int          m_row = 0;
    logic [15:0] m_addr = '0;
    logic [7:0]  m_wdata = '0;

    always #2 clk = ~clk;

    bus_cycle_seq u0 (
        .clk(clk), .rst(rst), .req_kind(req_kind), .req_addr(req_addr),
        .req_wdata(req_wdata), .mem_req_n(mem_req_n), .rd_n(rd_n), .wr_n(wr_n),
        .fetch_n(fetch_n), .refresh_n(refresh_n), .rfsh_addr(rfsh_addr),
        .bus_addr(bus_addr), .wr_data(wr_data), .wr_data_oe(wr_data_oe),
        .sample_stb(sample_stb)
    );

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s at %0t: actual %0h expected %0h", tag, what, $time, act, exp);
        end
    endtask

    function automatic int last_t(int k);
        return (k == 1) ? 4 : 3;
    endfunction

    function automatic string area_tag();
        if (m_t == 0)                  return "R9";
        if (m_t == 1)                  return "R1";
        if (m_kind == 1 && m_t <= 2)   return "R2";
        if (m_kind == 1)               return "R4";
        return "R6";
    endfunction

    task automatic model_edge();
        if (rst) begin
            m_kind = 0; m_t = 0; m_row = 0;
            m_addr = '0; m_wdata = '0;
        end else if (m_t == 0 || m_t == last_t(m_kind)) begin
            if (m_kind == 1 && m_t == 4) m_row = (m_row + 1) % 128;
            if (req_kind != 2'b00) begin
                m_kind = int'(req_kind); m_t = 1;
                m_addr = req_addr; m_wdata = req_wdata;
            end else begin
                m_kind = 0; m_t = 0;
            end
        end else begin
            m_t++;
        end
    endtask

    task automatic compare(bit late);
        bit fetch, data, win, e_mreq;
        string tg;
        fetch  = (m_kind == 1);
        data   = (m_kind >= 2);
        win    = data && ((m_t == 1 && late) || m_t == 2 || m_t == 3);
        e_mreq = (fetch && ((m_t == 1 && late) || m_t == 2 ||
                            (m_t == 3 && late) || (m_t == 4 && !late))) || win;
        tg = area_tag();
        check(tg,   "mem_req_n", 32'(mem_req_n), 32'(!e_mreq));
        check(tg,   "rd_n", 32'(rd_n),
              32'(!((fetch && ((m_t == 1 && late) || m_t == 2)) || (win && m_kind == 2))));
        check("R7", "wr_n", 32'(wr_n), 32'(!(win && m_kind == 3)));
        check("R3", "fetch_n", 32'(fetch_n), 32'(!(fetch && (m_t == 1 || m_t == 2))));
        check("R4", "refresh_n", 32'(refresh_n), 32'(!(fetch && (m_t == 3 || m_t == 4))));
        check("R5", "rfsh_addr", 32'(rfsh_addr), 32'(m_row));
        check("R8", "sample_stb", 32'(sample_stb),
              32'((fetch && m_t == 2) || (m_kind == 2 && m_t == 3)));
        check("R7", "wr_data_oe", 32'(wr_data_oe), 32'(m_kind == 3 && m_t != 0));
        if (m_kind == 3 && m_t != 0) check("R7", "wr_data", 32'(wr_data), 32'(m_wdata));
        if (m_t != 0) check("R10", "bus_addr", 32'(bus_addr), 32'(m_addr));
    endtask

    function automatic logic [1:0] stim(int i);
        if (i < 40) begin
            case (i % 7)
                0: return 2'b01;
                1: return 2'b00;
                2: return 2'b10;
                3: return 2'b11;
                4: return 2'b11;
                5: return 2'b01;
                default: return 2'b10;
            endcase
        end
        if (i < 640) return 2'b01;   // long fetch run: refresh row wraps (R5)
        if (i < 660) return 2'b00;
        return 2'((i * 5) % 4);
    endfunction

    initial begin
        fork
            begin
                for (int i = 0; i < 800; i++) begin
                    rst       = (i < 4) || (i == 702);
                    req_kind  = stim(i);
                    req_addr  = 16'(i * 40503);
                    req_wdata = 8'(i * 7 + 3);
                    @(posedge clk);
                    model_edge();
                    #1;
                    compare(1'b0);
                    @(negedge clk);
                    #1;
                    compare(1'b1);
                end
            end
            begin
                #(200000 * 4);
                n_errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule